// File: doc/BRIEF.md
# Step-coded four-channel PWM generator

This block drives four pulse-width-modulated outputs from a small write-only register file. Each channel has four settings. The first is an 8-bit frequency code made of a 2-bit range select and a 6-bit multiplier. The second is an 8-bit duty code. The third is a bit that inverts the output. The fourth is a bit that enables the channel. A shared clock-enable tick, divided down from the system clock by a parameter, advances a fractional phase accumulator per channel. The top eight bits of each accumulator form a 256-position phase. A channel's output is high while that phase is not above its duty code.

The output rate is the multiplier plus one, times a range unit. Range select 0 gives a unit of 1 accumulator count per tick, and each higher select multiplies the unit by four. With the default 20-bit accumulator, a tick rate of 2^20 × 0.5 Hz gives outputs from 0.5 Hz to 2048 Hz, in steps of 0.5, 2, 8 or 32 Hz. A register write acts on the very next tick. Nothing clears the accumulators after reset, so a cycle in progress when a write lands mixes the old and new settings. The duty code sets the high fraction to (code+1)/256. A full-on output is reachable, but a fully-off output is only possible by disabling the channel.

Top module: `stepcode_pwm`

## Requirements
- R1: After reset every setting is zero, every channel is disabled and all four outputs are low.
- R2: The frequency code of channel i is at address 0x08+i. Bits 7:6 hold the range select s and bits 5:0 hold the multiplier c. The output period is 2^ACC_W / ((c+1)·4^s) ticks.
- R3: The duty code d of channel i is at address 0x0C+i. The output is high for (d+1)/256 of each period, starting at the phase wrap. A code of 255 holds the output high, and a code of 0 still gives a high pulse of 1/256 of the period.
- R4: Bit i+2 of address 0x05 inverts channel i when it is set.
- R5: Bit i+4 of address 0x07 enables channel i. A disabled channel's output is low whatever its invert bit holds.
- R6: A write to any address other than 0x05, 0x07 and 0x08 to 0x0F changes no setting and no output.
- R7: A write to a setting applies from the next tick. The phase accumulator is not restarted, so a duty change inside a high interval lengthens or shortens that same interval.
- R8: The accumulators advance only on the shared tick, which fires once every TICK_DIV clocks. A high interval of one phase position lasts (2^ACC_W/256/inc)·TICK_DIV clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (5) | Register write address |
| wr_data | input | 8 | Register write data |
| pwm_o | output | 4 | Channel outputs, bit i is channel i |

## Verification
A register write and an accumulator step can land in the same clock. When this happens, the duty compare uses the new code against a phase that keeps running. To provoke this, the bench waits for a channel's rising edge and then, 100 clocks into the high interval, raises that channel's duty code. It judges the result by the length of the whole high interval measured from that edge. The interval must equal the new high time, which is the case only if the write took effect at once and the phase was not restarted. Restarting the accumulator would instead add the 100 elapsed clocks on top of the new high time.

// File: rtl/stepcode_pwm_pkg.sv
package stepcode_pwm_pkg;

    localparam int NUM_CH    = 4;
    localparam int PHASE_W   = 8;
    localparam int DATA_W    = 8;
    localparam int INC_W     = 13;

    localparam int ADDR_INV  = 'h05;
    localparam int ADDR_ENA  = 'h07;
    localparam int ADDR_FREQ = 'h08;
    localparam int ADDR_DUTY = 'h0C;
    localparam int INV_LSB   = 2;
    localparam int ENA_LSB   = 4;

    typedef struct packed {
        logic [1:0] range;
        logic [5:0] mult;
    } freq_code_t;

    typedef struct packed {
        freq_code_t        freq;
        logic [DATA_W-1:0] duty;
        logic              inv;
        logic              ena;
    } chan_cfg_t;

    // Accumulator increment per tick: (mult+1) * 4^range
    function automatic logic [INC_W-1:0] rate_inc(input freq_code_t f);
        logic [INC_W-1:0] base;
        base = INC_W'({7'd0, f.mult}) + INC_W'(1);
        return base << (2 * f.range);
    endfunction

    function automatic logic addr_mapped(input int a);
        return (a == ADDR_INV) || (a == ADDR_ENA) ||
               (a >= ADDR_FREQ && a < ADDR_DUTY + NUM_CH);
    endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);

    generate
        if (TICK_DIV > 1) begin : g_div
            localparam int CW = $clog2(TICK_DIV);
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (rst || cnt_q == CW'(TICK_DIV - 1)) cnt_q <= '0;
                else                                   cnt_q <= cnt_q + CW'(1);
            end

            assign tick_o = (cnt_q == CW'(TICK_DIV - 1));

            assert_tick_gap_R8: assert property (@(posedge clk) disable iff (rst)
                tick_o |=> !tick_o);
        end else begin : g_pass
            assign tick_o = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/pwm_regfile.sv
module pwm_regfile
    import stepcode_pwm_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en_i,
    input  logic [ADDR_W-1:0]        wr_addr_i,
    input  logic [DATA_W-1:0]        wr_data_i,
    output chan_cfg_t [NUM_CH-1:0]   cfg_o
);

    logic [NUM_CH-1:0] inv_q;
    logic [NUM_CH-1:0] ena_q;
    freq_code_t        freq_q [NUM_CH];
    logic [DATA_W-1:0] duty_q [NUM_CH];

    always_ff @(posedge clk) begin
        if (rst) begin
            inv_q <= '0;
            ena_q <= '0;
            for (int i = 0; i < NUM_CH; i++) begin
                freq_q[i] <= '0;
                duty_q[i] <= '0;
            end
        end else if (wr_en_i) begin
            if (wr_addr_i == ADDR_W'(ADDR_INV)) inv_q <= wr_data_i[INV_LSB +: NUM_CH];
            if (wr_addr_i == ADDR_W'(ADDR_ENA)) ena_q <= wr_data_i[ENA_LSB +: NUM_CH];
            for (int i = 0; i < NUM_CH; i++) begin
                if (wr_addr_i == ADDR_W'(ADDR_FREQ + i)) freq_q[i] <= freq_code_t'(wr_data_i);
                if (wr_addr_i == ADDR_W'(ADDR_DUTY + i)) duty_q[i] <= wr_data_i;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            cfg_o[i].freq = freq_q[i];
            cfg_o[i].duty = duty_q[i];
            cfg_o[i].inv  = inv_q[i];
            cfg_o[i].ena  = ena_q[i];
        end
    end

    logic addr_hit;
    assign addr_hit = addr_mapped(int'(wr_addr_i));

    assert_freq_write_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en_i && wr_addr_i == ADDR_W'(ADDR_FREQ) |=> cfg_o[0].freq == $past(wr_data_i));

    assert_unmapped_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en_i && !addr_hit |=> $stable(cfg_o));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import stepcode_pwm_pkg::*;
#(
    parameter int ACC_W = 20
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick_i,
    input  chan_cfg_t cfg_i,
    output logic      pwm_o
);

    logic [ACC_W-1:0]   acc_q;
    logic [ACC_W-1:0]   inc;
    logic [PHASE_W-1:0] phase;
    logic               raw_high;

    assign inc      = ACC_W'(rate_inc(cfg_i.freq));
    assign phase    = acc_q[ACC_W-1 -: PHASE_W];
    assign raw_high = (phase <= cfg_i.duty);

    always_ff @(posedge clk) begin
        if (rst)         acc_q <= '0;
        else if (tick_i) acc_q <= acc_q + inc;
    end

    always_ff @(posedge clk) begin
        if (rst) pwm_o <= 1'b0;
        else     pwm_o <= cfg_i.ena & (raw_high ^ cfg_i.inv);
    end

    assert_phase_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(acc_q));

    assert_full_on_R3: assert property (@(posedge clk) disable iff (rst)
        cfg_i.ena && !cfg_i.inv && cfg_i.duty == 8'hFF |=> pwm_o);

    assert_full_inverted_R4: assert property (@(posedge clk) disable iff (rst)
        cfg_i.ena && cfg_i.inv && cfg_i.duty == 8'hFF |=> !pwm_o);

    assert_disabled_low_R5: assert property (@(posedge clk) disable iff (rst)
        !cfg_i.ena |=> !pwm_o);

endmodule

// File: rtl/stepcode_pwm.sv
module stepcode_pwm
    import stepcode_pwm_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int ACC_W    = 20,
    parameter int TICK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic [3:0]        pwm_o
);

    logic                   tick;
    chan_cfg_t [NUM_CH-1:0] cfg;

    pwm_timebase #(.TICK_DIV(TICK_DIV)) u_tb (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    pwm_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .cfg_o     (cfg)
    );

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            pwm_channel #(.ACC_W(ACC_W)) u_ch (
                .clk    (clk),
                .rst    (rst),
                .tick_i (tick),
                .cfg_i  (cfg[i]),
                .pwm_o  (pwm_o[i])
            );
        end
    endgenerate

    assert_reset_low_R1: assert property (@(posedge clk)
        rst |=> pwm_o == 4'b0000);

endmodule

// File: tb/stepcode_pwm_test.sv
module stepcode_pwm_test;

    localparam int DIV = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] pwm_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    stepcode_pwm #(.ADDR_W(5), .ACC_W(20), .TICK_DIV(DIV)) uut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_o   (pwm_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_rise(input int ch);
        logic p;
        p = pwm_o[ch];
        @(negedge clk);
        while (!(!p && pwm_o[ch])) begin
            p = pwm_o[ch];
            @(negedge clk);
        end
    endtask

    // Skips one rising edge so the measured period is untouched by setup writes
    task automatic measure(input int ch, output int hi, output int lo);
        wait_rise(ch);
        wait_rise(ch);
        hi = 0;
        while (pwm_o[ch]) begin hi++; @(negedge clk); end
        lo = 0;
        while (!pwm_o[ch]) begin lo++; @(negedge clk); end
    endtask

    task automatic count_level(input int ch, input logic lvl, input int n, output int cnt);
        cnt = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (pwm_o[ch] == lvl) cnt++;
        end
    endtask

    task automatic t_reset;
        int bad;
        bad = 0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (pwm_o != 4'b0000) bad++;
        end
        chk("R1 outputs low after reset", bad, 0);
    endtask

    task automatic t_ch0_half;
        int hi, lo;
        wr(5'h08, 8'hCF);
        wr(5'h0C, 8'd127);
        wr(5'h07, 8'h10);
        measure(0, hi, lo);
        chk("R3 ch0 high time duty 127", hi, 512 * DIV);
        chk("R2 ch0 low time range 3 mult 15", lo, 512 * DIV);
    endtask

    task automatic t_ch1_fast;
        int hi, lo;
        wr(5'h09, 8'hFF);
        wr(5'h0D, 8'd63);
        wr(5'h07, 8'h30);
        measure(1, hi, lo);
        chk("R2 ch1 high time max rate", hi, 64 * DIV);
        chk("R2 ch1 low time max rate", lo, 192 * DIV);
        wr(5'h0D, 8'd0);
        measure(1, hi, lo);
        chk("R8 one phase position lasts one tick", hi, 1 * DIV);
        chk("R8 remaining period", lo, 255 * DIV);
        wr(5'h0D, 8'd63);
    endtask

    task automatic t_ch2_min;
        int hi, lo;
        wr(5'h0A, 8'h9F);
        wr(5'h0E, 8'd0);
        wr(5'h07, 8'h70);
        measure(2, hi, lo);
        chk("R3 duty 0 still pulses", hi, 8 * DIV);
        chk("R2 ch2 low time range 2", lo, 2040 * DIV);
    endtask

    task automatic t_ch3_slow;
        int hi, lo;
        wr(5'h0B, 8'h3F);
        wr(5'h0F, 8'd127);
        wr(5'h07, 8'hF0);
        measure(3, hi, lo);
        chk("R2 ch3 high time range 0", hi, 8192 * DIV);
        chk("R2 ch3 low time range 0", lo, 8192 * DIV);
        wr(5'h07, 8'h70);
    endtask

    task automatic t_full_on;
        int lows;
        wr(5'h0C, 8'hFF);
        @(negedge clk);
        count_level(0, 1'b0, 2200, lows);
        chk("R3 duty 255 holds output high", lows, 0);
    endtask

    task automatic t_invert;
        int hi, lo;
        wr(5'h05, 8'h08);
        measure(1, hi, lo);
        chk("R4 inverted high time", hi, 192 * DIV);
        chk("R4 inverted low time", lo, 64 * DIV);
    endtask

    task automatic t_disable_inv;
        int highs;
        wr(5'h07, 8'h50);
        @(negedge clk);
        count_level(1, 1'b1, 600, highs);
        chk("R5 disabled inverted channel stays low", highs, 0);
    endtask

    task automatic t_unmapped;
        int cnt, hi, lo;
        wr(5'h06, 8'hFF);
        wr(5'h04, 8'hFF);
        wr(5'h10, 8'hFF);
        wr(5'h1F, 8'hFF);
        wr(5'h03, 8'hFF);
        @(negedge clk);
        count_level(1, 1'b1, 600, cnt);
        chk("R6 enable untouched by unmapped writes", cnt, 0);
        count_level(0, 1'b0, 600, cnt);
        chk("R6 ch0 duty untouched by unmapped writes", cnt, 0);
        measure(2, hi, lo);
        chk("R6 ch2 pulse unchanged", hi, 8 * DIV);
    endtask

    task automatic t_retune;
        int hi, lo;
        wr(5'h0C, 8'd31);
        measure(0, hi, lo);
        chk("R7 new duty high time", hi, 128 * DIV);
        chk("R7 new duty low time", lo, 896 * DIV);
    endtask

    task automatic t_live_change;
        int hi;
        wait_rise(0);
        hi = 1;
        for (int k = 0; k < 99; k++) begin
            @(negedge clk);
            if (pwm_o[0]) hi++;
        end
        wr_en = 1'b1; wr_addr = 5'h0C; wr_data = 8'd127;
        @(negedge clk);
        wr_en = 1'b0;
        if (pwm_o[0]) hi++;
        for (int k = 0; k < 5000 && pwm_o[0]; k++) begin
            @(negedge clk);
            if (pwm_o[0]) hi++;
        end
        chk("R7 mid-interval duty raise, phase not restarted", hi, 512 * DIV);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ch0_half();
        t_ch1_fast();
        t_ch2_min();
        t_ch3_slow();
        t_full_on();
        t_invert();
        t_disable_inv();
        t_unmapped();
        t_retune();
        t_live_change();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule